// File: doc/BRIEF.md
# IDE Channel Base Address Decoder

This block turns the configuration state of a two-channel IDE host interface into I/O chip selects. For each channel it produces a command-block select that covers eight consecutive byte addresses and a control-block select that covers a single byte address. Each channel chooses its own addresses. It uses either its own pair of base address registers (native mode) or the fixed addresses that older software expects (legacy mode).

The block holds the four base address registers, the programming-interface byte and the command byte. They are written through a byte-wide configuration write port that uses standard configuration-space offsets. Two more inputs come from neighbouring configuration logic. One input allows native mode and allows writes to the base address registers. The other enables the secondary channel. All register contents are brought out for readback.

The chip selects are combinational from the I/O address and the registered configuration. A configuration write takes effect on decode from the cycle after the clock edge that captures it.

Top module: `ide_base_decoder`

## Requirements
- R1: After reset the base registers read 0x01F1 (primary command), 0x03F5 (primary control), 0x0171 (secondary command) and 0x0375 (secondary control). The command byte reads 0x01 and the programming-interface byte reads the parameter PROGIF_RST (default 0x0A).
- R2: A channel in legacy mode selects its command block for 0x1F0–0x1F7 (primary) or 0x170–0x177 (secondary). It selects its control block only at 0x3F6 (primary) or 0x376 (secondary).
- R3: A channel is in native mode only when native_en is 1 and its programming-interface bit is set (bit 0 for primary, bit 2 for secondary). In native mode the command block spans the 8 bytes from the command register with bits 2:0 cleared. The control block is the single byte at the control register with bits 1:0 cleared, plus 2.
- R4: A write of d to a base register low byte stores {d[7:3],3'b001} for a command register or {d[7:2],2'b01} for a control register. A write to a high byte stores d unchanged. The offsets are: 0x10/0x11 primary command, 0x14/0x15 primary control, 0x18/0x19 secondary command, 0x1C/0x1D secondary control (low byte/high byte).
- R5: Writes to any base register leave it unchanged while native_en is 0.
- R6: A write to the programming-interface byte (offset 0x09) is accepted only when its bits 1 and 3 are both 1. An accepted write replaces bits 0 and 2 from the data, keeps bits 1 and 3, and clears the other bits. A write that is not accepted leaves the byte unchanged.
- R7: A write to the command byte (offset 0x04) keeps only bits 0 and 6 of the data. The other bits read as zero.
- R8: No select for the primary channel is active unless command bit 0 is 1. No select for the secondary channel is active unless command bit 0 is 1 and sec_en is 1.
- R9: The mode choice is made per channel. One channel can decode native addresses while the other decodes legacy addresses.
- R10: The address just below a command block and the address just after it are not selected. The bytes on either side of a control address are not selected.
- R11: A configuration write presented in the same cycle as an I/O address does not change that cycle's selects. The new value governs decode from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| native_en | input | 1 | Allows native mode and base register writes |
| sec_en | input | 1 | Secondary channel enable |
| io_addr | input | 16 | I/O address being decoded |
| cmd_cs | output | 2 | Command-block selects, bit 0 primary, bit 1 secondary |
| ctl_cs | output | 2 | Control-block selects, bit 0 primary, bit 1 secondary |
| pri_cmd_bar | output | 16 | Primary command base register readback |
| pri_ctl_bar | output | 16 | Primary control base register readback |
| sec_cmd_bar | output | 16 | Secondary command base register readback |
| sec_ctl_bar | output | 16 | Secondary control base register readback |
| progif_q | output | 8 | Programming-interface byte readback |
| command_q | output | 8 | Command byte readback |

## Verification
Two functions can fall in the same cycle: a configuration write that moves a channel's decode window, and an I/O address probe of that window. The bench drives a write to the primary command base high byte together with an address inside the current window. It checks that the select is still active before the capturing edge. After the edge it checks that the old window no longer decodes and the new one does. Switching modes per channel is judged the same way, by probing both the legacy and the native windows of each channel after every programming-interface write.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  localparam int NCH    = 2;
  localparam int AW     = 16;
  localparam int DW     = 8;
  localparam int KINDS  = 2;   // 0: command block, 1: control block
  localparam logic [7:0] OFS_COMMAND = 8'h04;
  localparam logic [7:0] OFS_PROGIF  = 8'h09;
  localparam logic [7:0] OFS_BAR0    = 8'h10;

  typedef logic [AW-1:0] addr_t;

  // Legacy command block base per channel
  function automatic addr_t f_leg_cmd(input int ch);
    return (ch == 0) ? 16'h01F0 : 16'h0170;
  endfunction

  // Legacy control byte per channel
  function automatic addr_t f_leg_ctl(input int ch);
    return (ch == 0) ? 16'h03F6 : 16'h0376;
  endfunction

  // Reset contents of a base register: legacy location, I/O indicator bit set
  function automatic addr_t f_bar_rst(input int ch, input int kind);
    if (kind == 0) return f_leg_cmd(ch) | 16'h0001;
    return (f_leg_ctl(ch) - 16'h0002) | 16'h0001;
  endfunction

  // Configuration offset of a base register low byte
  function automatic logic [7:0] f_bar_ofs(input int ch, input int kind);
    return OFS_BAR0 + 8'(ch * 8) + 8'(kind * 4);
  endfunction

  // Value stored on a low-byte write
  function automatic logic [7:0] f_low_store(input int kind, input logic [7:0] d);
    if (kind == 0) return {d[7:3], 3'b001};
    return {d[7:2], 2'b01};
  endfunction

  function automatic addr_t f_cmd_base(input addr_t bar);
    return {bar[AW-1:3], 3'b000};
  endfunction

  function automatic addr_t f_ctl_addr(input addr_t bar);
    return {bar[AW-1:2], 2'b00} + 16'h0002;
  endfunction

  function automatic logic f_in_block8(input addr_t a, input addr_t base);
    return a[AW-1:3] == base[AW-1:3];
  endfunction
endpackage

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs
  import ide_dec_pkg::*;
#(
  parameter logic [7:0] PROGIF_RST = 8'h0A,
  parameter logic [7:0] CMD_RST    = 8'h01,
  parameter logic [7:0] CMD_KEEP   = 8'h41
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [7:0]    progif_q,
  output logic [7:0]    command_q
);
  localparam logic [7:0] PI_LOCK_BITS = 8'h0A;
  localparam logic [7:0] PI_MODE_BITS = 8'h05;

  logic pi_hit, pi_accept, cmd_hit;
  assign pi_hit    = cfg_wr && (cfg_addr == OFS_PROGIF);
  assign pi_accept = pi_hit && ((progif_q & PI_LOCK_BITS) == PI_LOCK_BITS);
  assign cmd_hit   = cfg_wr && (cfg_addr == OFS_COMMAND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      progif_q  <= PROGIF_RST;
      command_q <= CMD_RST;
    end else begin
      if (pi_accept)
        progif_q <= (progif_q & PI_LOCK_BITS) | (cfg_wdata & PI_MODE_BITS);
      if (cmd_hit)
        command_q <= cfg_wdata & CMD_KEEP;
    end
  end

  // R6: lock bits never move
  a_r6_lock_stable: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(progif_q & PI_LOCK_BITS));
  // R6: rejected write leaves the byte unchanged
  a_r6_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pi_hit && !pi_accept) |=> $stable(progif_q));
  // R7: only kept bits of the command byte are ever set
  a_r7_cmd_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (command_q & ~CMD_KEEP) == 8'h00);
endmodule

// File: rtl/ide_bar_regs.sv
module ide_bar_regs
  import ide_dec_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          native_en,
  output addr_t         bar_q [NCH][KINDS]
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    for (genvar k = 0; k < KINDS; k++) begin : g_kind
      localparam logic [7:0] OFS_LO = f_bar_ofs(ch, k);
      localparam logic [7:0] OFS_HI = OFS_LO + 8'h01;
      localparam addr_t      RST_V  = f_bar_rst(ch, k);

      logic wr_lo, wr_hi, wr_try;
      assign wr_try = cfg_wr && ((cfg_addr == OFS_LO) || (cfg_addr == OFS_HI));
      assign wr_lo  = cfg_wr && native_en && (cfg_addr == OFS_LO);
      assign wr_hi  = cfg_wr && native_en && (cfg_addr == OFS_HI);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          bar_q[ch][k] <= RST_V;
        end else begin
          if (wr_lo) bar_q[ch][k][7:0]  <= f_low_store(k, cfg_wdata);
          if (wr_hi) bar_q[ch][k][15:8] <= cfg_wdata;
        end
      end

      // R5: writes ignored while native mode is not allowed
      a_r5_gated_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_try && !native_en) |=> $stable(bar_q[ch][k]));
      // R4: I/O indicator bit always reads one
      a_r4_io_bit: assert property (@(posedge clk) disable iff (!rst_n)
        bar_q[ch][k][0] == 1'b1);
    end
  end
endmodule

// File: rtl/ide_chan_decode.sv
module ide_chan_decode
  import ide_dec_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  chan_en,
  input  logic  native,
  input  addr_t cmd_bar,
  input  addr_t ctl_bar,
  input  addr_t io_addr,
  output logic  cmd_cs,
  output logic  ctl_cs
);
  localparam addr_t LEG_CMD = f_leg_cmd(CH);
  localparam addr_t LEG_CTL = f_leg_ctl(CH);

  addr_t cmd_base_w, ctl_addr_w;
  logic  cmd_hit_w, ctl_hit_w;

  assign cmd_base_w = native ? f_cmd_base(cmd_bar) : LEG_CMD;
  assign ctl_addr_w = native ? f_ctl_addr(ctl_bar) : LEG_CTL;
  assign cmd_hit_w  = f_in_block8(io_addr, cmd_base_w);
  assign ctl_hit_w  = (io_addr == ctl_addr_w);
  assign cmd_cs     = chan_en && cmd_hit_w;
  assign ctl_cs     = chan_en && ctl_hit_w;

  // R2: legacy command select only inside the fixed window
  a_r2_legacy_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cs && !native) |-> (io_addr[15:3] == LEG_CMD[15:3]));
  // R10: control select covers a single byte
  a_r10_ctl_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_cs && native) |-> (io_addr[1:0] == 2'b10));
endmodule

// File: rtl/ide_base_decoder.sv
module ide_base_decoder
  import ide_dec_pkg::*;
#(
  parameter logic [7:0] PROGIF_RST = 8'h0A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  input  logic        native_en,
  input  logic        sec_en,
  input  logic [15:0] io_addr,
  output logic [1:0]  cmd_cs,
  output logic [1:0]  ctl_cs,
  output logic [15:0] pri_cmd_bar,
  output logic [15:0] pri_ctl_bar,
  output logic [15:0] sec_cmd_bar,
  output logic [15:0] sec_ctl_bar,
  output logic [7:0]  progif_q,
  output logic [7:0]  command_q
);
  addr_t bar_q [NCH][KINDS];
  logic [NCH-1:0] chan_en_w, native_w;

  ide_cfg_regs #(.PROGIF_RST(PROGIF_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .progif_q(progif_q), .command_q(command_q)
  );

  ide_bar_regs u_bars (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .native_en(native_en), .bar_q(bar_q)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
    if (ch == 0) begin : g_pri
      assign chan_en_w[ch] = command_q[0];
    end else begin : g_sec
      assign chan_en_w[ch] = command_q[0] && sec_en;
    end
    assign native_w[ch] = native_en && progif_q[2*ch];

    ide_chan_decode #(.CH(ch)) u_dec (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en_w[ch]), .native(native_w[ch]),
      .cmd_bar(bar_q[ch][0]), .ctl_bar(bar_q[ch][1]), .io_addr(io_addr),
      .cmd_cs(cmd_cs[ch]), .ctl_cs(ctl_cs[ch])
    );
  end

  assign pri_cmd_bar = bar_q[0][0];
  assign pri_ctl_bar = bar_q[0][1];
  assign sec_cmd_bar = bar_q[1][0];
  assign sec_ctl_bar = bar_q[1][1];

  // R8: no select without the decode enable of that channel
  a_r8_pri_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !command_q[0] |-> (cmd_cs == 2'b00 && ctl_cs == 2'b00));
  a_r8_sec_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_en |-> (!cmd_cs[1] && !ctl_cs[1]));
endmodule

// File: tb/tb_ide_base_decoder.sv
module tb_ide_base_decoder;
  localparam int PERIOD = 10;
  localparam int NVEC = 12;
  // {io_addr, expected cmd_cs, expected ctl_cs} for legacy decode, both channels on
  localparam logic [19:0] VEC [NVEC] = '{
    {16'h01F0, 2'b01, 2'b00}, {16'h01F7, 2'b01, 2'b00},
    {16'h01F8, 2'b00, 2'b00}, {16'h01EF, 2'b00, 2'b00},
    {16'h03F6, 2'b00, 2'b01}, {16'h03F7, 2'b00, 2'b00},
    {16'h03F5, 2'b00, 2'b00}, {16'h0170, 2'b10, 2'b00},
    {16'h0177, 2'b10, 2'b00}, {16'h0178, 2'b00, 2'b00},
    {16'h0376, 2'b00, 2'b10}, {16'h0377, 2'b00, 2'b00}
  };

  logic clk = 0, rst_n = 0, cfg_wr = 0, native_en = 0, sec_en = 1;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0;
  logic [15:0] io_addr = 0;
  logic [1:0] cmd_cs, ctl_cs, cmd_cs_f, ctl_cs_f;
  logic [15:0] pcb, pkb, scb, skb, pcb_f, pkb_f, scb_f, skb_f;
  logic [7:0] progif_q, command_q, progif_f, command_f;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  ide_base_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .native_en(native_en), .sec_en(sec_en),
    .io_addr(io_addr), .cmd_cs(cmd_cs), .ctl_cs(ctl_cs),
    .pri_cmd_bar(pcb), .pri_ctl_bar(pkb), .sec_cmd_bar(scb), .sec_ctl_bar(skb),
    .progif_q(progif_q), .command_q(command_q)
  );

  // Instance whose programming-interface byte starts locked
  ide_base_decoder #(.PROGIF_RST(8'h00)) dut_fixed (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .native_en(native_en), .sec_en(sec_en),
    .io_addr(io_addr), .cmd_cs(cmd_cs_f), .ctl_cs(ctl_cs_f),
    .pri_cmd_bar(pcb_f), .pri_ctl_bar(pkb_f), .sec_cmd_bar(scb_f), .sec_ctl_bar(skb_f),
    .progif_q(progif_f), .command_q(command_f)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic probe(input string req, input logic [15:0] a,
                       input logic [1:0] ecmd, input logic [1:0] ectl);
    io_addr = a;
    #1;
    chk(req, {14'd0, cmd_cs, 14'd0, ctl_cs}, {14'd0, ecmd, 14'd0, ectl});
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pri_cmd", pcb, 16'h01F1);
    chk("R1 pri_ctl", pkb, 16'h03F5);
    chk("R1 sec_cmd", scb, 16'h0171);
    chk("R1 sec_ctl", skb, 16'h0375);
    chk("R1 progif", progif_q, 8'h0A);
    chk("R1 command", command_q, 8'h01);

    // R2 / R10 legacy table
    foreach (VEC[i]) probe("R2/R10 legacy", VEC[i][19:4], VEC[i][3:2], VEC[i][1:0]);

    // R8 secondary enable and command gating
    sec_en = 0;
    probe("R8 sec off", 16'h0170, 2'b00, 2'b00);
    probe("R8 sec ctl off", 16'h0376, 2'b00, 2'b00);
    probe("R8 pri unaffected", 16'h01F0, 2'b01, 2'b00);
    sec_en = 1;
    wr(8'h04, 8'h00);
    probe("R8 cmd bit0 off pri", 16'h01F0, 2'b00, 2'b00);
    probe("R8 cmd bit0 off sec", 16'h0376, 2'b00, 2'b00);
    // R7 command mask
    wr(8'h04, 8'hFF);
    chk("R7 command", command_q, 8'h41);
    probe("R8 cmd on", 16'h01F3, 2'b01, 2'b00);

    // R5 gated writes
    wr(8'h10, 8'h00);
    wr(8'h11, 8'hAB);
    chk("R5 pri_cmd hold", pcb, 16'h01F1);
    wr(8'h1C, 8'h00);
    chk("R5 sec_ctl hold", skb, 16'h0375);

    // R4 storage masks
    native_en = 1;
    wr(8'h10, 8'hFF);
    chk("R4 cmd low", pcb, 16'h01F9);
    wr(8'h11, 8'h12);
    chk("R4 cmd high", pcb, 16'h12F9);
    wr(8'h14, 8'hFF);
    wr(8'h15, 8'h34);
    chk("R4 ctl", pkb, 16'h34FD);
    wr(8'h18, 8'h80); wr(8'h19, 8'h20);
    wr(8'h1C, 8'h40); wr(8'h1D, 8'h21);
    chk("R4 sec_cmd", scb, 16'h2081);
    chk("R4 sec_ctl", skb, 16'h2141);

    // R3 progif bit clear keeps legacy
    probe("R3 legacy w/o progif", 16'h01F0, 2'b01, 2'b00);
    probe("R3 native not yet", 16'h12F8, 2'b00, 2'b00);

    // R6 accepted write, R9 primary native, secondary legacy
    wr(8'h09, 8'hF1);
    chk("R6 progif", progif_q, 8'h0B);
    probe("R3 pri native lo", 16'h12F8, 2'b01, 2'b00);
    probe("R3 pri native hi", 16'h12FF, 2'b01, 2'b00);
    probe("R10 after block", 16'h1300, 2'b00, 2'b00);
    probe("R10 before block", 16'h12F7, 2'b00, 2'b00);
    probe("R3 pri ctl", 16'h34FE, 2'b00, 2'b01);
    probe("R10 ctl below", 16'h34FD, 2'b00, 2'b00);
    probe("R10 ctl above", 16'h34FF, 2'b00, 2'b00);
    probe("R9 pri legacy gone", 16'h01F0, 2'b00, 2'b00);
    probe("R9 sec legacy", 16'h0170, 2'b10, 2'b00);
    probe("R9 sec native unused", 16'h2080, 2'b00, 2'b00);

    // R9 swap: primary legacy, secondary native
    wr(8'h09, 8'h04);
    chk("R6 progif swap", progif_q, 8'h0E);
    probe("R9 pri legacy", 16'h01F0, 2'b01, 2'b00);
    probe("R9 pri native gone", 16'h12F8, 2'b00, 2'b00);
    probe("R3 sec native cmd", 16'h2087, 2'b10, 2'b00);
    probe("R3 sec native ctl", 16'h2142, 2'b00, 2'b10);
    probe("R10 sec ctl base", 16'h2140, 2'b00, 2'b00);
    probe("R9 sec legacy gone", 16'h0376, 2'b00, 2'b00);

    // R3 native_en off forces legacy everywhere
    native_en = 0;
    probe("R3 native_en off sec", 16'h0170, 2'b10, 2'b00);
    probe("R3 native_en off ctl", 16'h2142, 2'b00, 2'b00);
    native_en = 1;

    // R6 locked instance rejects writes
    chk("R6 locked start", progif_f, 8'h00);
    wr(8'h09, 8'h05);
    chk("R6 locked reject", progif_f, 8'h00);
    chk("R6 unlocked accept", progif_q, 8'h0F);

    // R11 same-cycle write and probe
    @(negedge clk);
    cfg_wr = 1; cfg_addr = 8'h11; cfg_wdata = 8'h55;
    probe("R11 old window same cycle", 16'h12F8, 2'b01, 2'b00);
    @(negedge clk);
    cfg_wr = 0;
    probe("R11 old window gone", 16'h12F8, 2'b00, 2'b00);
    probe("R11 new window", 16'h55FC, 2'b01, 2'b00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule